// File: doc/BRIEF.md
# Relative Branch and Loop Counter Unit

This unit resolves the short relative branches of a CPU with a 24-bit program counter. Four kinds of branch are handled. The first jumps every time. The second jumps only when the zero flag is clear. The third jumps only when the zero flag is set. The fourth is a counting loop: it first lowers the 8-bit B register by one, then jumps only if the new B is not zero. Each request supplies these inputs:

- the branch class;
- the signed displacement byte;
- the program counter, already pointing past the two-byte branch;
- the zero flag;
- the current B.

The unit returns the next program counter, the new B and a taken indication. A one-cycle `done` strobe marks the end of the instruction's cycle budget. The length of that budget depends on the class and on whether the branch was taken.

Requests enter through a valid/ready handshake. `req_ready` is high whenever no operation is in flight. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. While an operation runs, `req_ready` is low and `req_valid` is ignored. The result side has no back-pressure: the result is announced by `done` and held on the result pins until the next request is accepted. The unit never changes a flag.

Top module: `relbranch_unit`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0, `taken` is 0, and `next_pc` and `b_out` are 0.
- R2: When a branch is taken, `next_pc` equals `req_pc` plus the displacement sign-extended to 24 bits, wrapping modulo 2^24.
- R3: When a branch is not taken, `next_pc` equals `req_pc` unchanged.
- R4: Class 2'b00 (always) is always taken and takes 3 cycles.
- R5: Class 2'b01 is taken exactly when `req_zf` is 0. Class 2'b10 is taken exactly when `req_zf` is 1. Each takes 3 cycles when taken and 2 when not taken.
- R6: Class 2'b11 (loop) gives `b_out` = `req_b` - 1 modulo 256, so 0 becomes 0xFF. It is taken exactly when that new value is non-zero, and takes 4 cycles when taken and 2 when not taken.
- R7: An operation of N cycles counts the accepting edge as its first cycle. `done` is high for exactly one cycle, the one that follows the edge N-1 edges after the accepting edge.
- R8: `req_ready` is low from the accepting edge until the edge that raises `done`. A `req_valid` presented in that window is ignored: it neither changes the result nor produces another `done`.
- R9: For classes other than the loop, `b_out` equals `req_b` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Branch request present |
| req_ready | output | 1 | Unit idle, request will be accepted |
| req_class | input | 2 | 00 always, 01 if zero clear, 10 if zero set, 11 loop on B |
| req_disp | input | 8 | Signed displacement |
| req_pc | input | 24 | Address of the instruction after the branch |
| req_zf | input | 1 | Zero flag |
| req_b | input | 8 | Current B register |
| done | output | 1 | One-cycle end-of-instruction strobe |
| taken | output | 1 | Branch was taken |
| next_pc | output | 24 | Resolved program counter |
| b_out | output | 8 | Updated B register |

## Verification
A result is due N-1 edges after the accepting edge, where N is 2, 3 or 4 depending on the class and the branch outcome. The driver counts edges and records the accepting edge. For each request it queues the expected `next_pc`, `b_out` and `taken`, together with the exact cycle number at which `done` must appear. The monitor samples on the falling edge. A `done` in any other cycle, a missing `done`, or a `done` with no pending request is reported against R7 or R8. A sequence of requests issued while the unit is busy checks that such requests leave no trace.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

  typedef enum logic [1:0] {
    BR_ALWAYS = 2'b00,
    BR_IF_NZ  = 2'b01,
    BR_IF_Z   = 2'b10,
    BR_LOOP   = 2'b11
  } br_class_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rbu_decide.sv
module rbu_decide
  import rbu_pkg::*;
#(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned ALWAYS_N = 3,
  parameter int unsigned COND_T_N = 3,
  parameter int unsigned COND_F_N = 2,
  parameter int unsigned LOOP_T_N = 4,
  parameter int unsigned LOOP_F_N = 2
) (
  input  br_class_e        cls,
  input  logic             zf,
  input  logic [REG_W-1:0] b_in,
  output logic             go,
  output logic [REG_W-1:0] b_next,
  output logic [CNT_W-1:0] cycles
);

  logic [REG_W-1:0] b_dec;

  assign b_dec = b_in - REG_W'(1);

  always_comb begin
    go     = 1'b0;
    b_next = b_in;
    cycles = CNT_W'(ALWAYS_N);
    unique case (cls)
      BR_ALWAYS: begin
        go     = 1'b1;
        cycles = CNT_W'(ALWAYS_N);
      end
      BR_IF_NZ: begin
        go     = ~zf;
        cycles = go ? CNT_W'(COND_T_N) : CNT_W'(COND_F_N);
      end
      BR_IF_Z: begin
        go     = zf;
        cycles = go ? CNT_W'(COND_T_N) : CNT_W'(COND_F_N);
      end
      BR_LOOP: begin
        b_next = b_dec;
        go     = |b_dec;
        cycles = go ? CNT_W'(LOOP_T_N) : CNT_W'(LOOP_F_N);
      end
      default: begin
        go     = 1'b0;
        cycles = CNT_W'(COND_F_N);
      end
    endcase
  end

endmodule

// File: rtl/rbu_target.sv
module rbu_target #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DISP_W = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              go,
  output logic [ADDR_W-1:0] dest
);

  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_noext
      assign disp_ext = disp[ADDR_W-1:0];
    end
  endgenerate

  assign dest = go ? (pc + disp_ext) : pc;

endmodule

// File: rtl/rbu_timer.sv
module rbu_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_n,
  output logic             busy,
  output logic             fire
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      fire   <= 1'b0;
      remain <= '0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        busy   <= 1'b1;
        remain <= load_n - CNT_W'(1);
      end else if (busy) begin
        if (remain == CNT_W'(1)) begin
          busy   <= 1'b0;
          fire   <= 1'b1;
          remain <= '0;
        end else begin
          remain <= remain - CNT_W'(1);
        end
      end
    end
  end

  // R7
  remain_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remain != '0));

  // R8
  fire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !busy);

endmodule

// File: rtl/relbranch_unit.sv
module relbranch_unit
  import rbu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DISP_W   = 8,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned ALWAYS_N = 3,
  parameter int unsigned COND_T_N = 3,
  parameter int unsigned COND_F_N = 2,
  parameter int unsigned LOOP_T_N = 4,
  parameter int unsigned LOOP_F_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_class,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic              req_zf,
  input  logic [REG_W-1:0]  req_b,
  output logic              done,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic [REG_W-1:0]  b_out
);

  localparam int unsigned MAX_N =
    max2(max2(ALWAYS_N, COND_T_N), max2(max2(COND_F_N, LOOP_T_N), LOOP_F_N));
  localparam int unsigned CNT_W = $clog2(MAX_N + 1);

  br_class_e        cls;
  logic             go;
  logic [REG_W-1:0] b_next;
  logic [CNT_W-1:0] cycles;
  logic [ADDR_W-1:0] dest;
  logic             busy;
  logic             accept;
  br_class_e        cls_q;

  assign cls       = br_class_e'(req_class);
  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;

  rbu_decide #(
    .CNT_W(CNT_W), .REG_W(REG_W), .ALWAYS_N(ALWAYS_N), .COND_T_N(COND_T_N),
    .COND_F_N(COND_F_N), .LOOP_T_N(LOOP_T_N), .LOOP_F_N(LOOP_F_N)
  ) u_decide (
    .cls(cls), .zf(req_zf), .b_in(req_b),
    .go(go), .b_next(b_next), .cycles(cycles)
  );

  rbu_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_target (
    .pc(req_pc), .disp(req_disp), .go(go), .dest(dest)
  );

  rbu_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_n(cycles),
    .busy(busy), .fire(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken   <= 1'b0;
      next_pc <= '0;
      b_out   <= '0;
      cls_q   <= BR_ALWAYS;
    end else if (accept) begin
      taken   <= go;
      next_pc <= dest;
      b_out   <= b_next;
      cls_q   <= cls;
    end
  end

  initial begin
    min_cycles_chk: assert (ALWAYS_N >= 2 && COND_T_N >= 2 && COND_F_N >= 2 &&
                            LOOP_T_N >= 2 && LOOP_F_N >= 2);
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!req_ready));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> ($stable(next_pc) && $stable(b_out) && $stable(taken)));

  // R4
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cls_q == BR_ALWAYS) |-> taken);

  // R6
  loop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cls_q == BR_LOOP) |-> (taken == (b_out != '0)));

endmodule

// File: tb/tb_relbranch_unit.sv
module tb_relbranch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_class = 2'b00;
  logic [7:0]  req_disp = 8'h00;
  logic [23:0] req_pc = 24'h0;
  logic        req_zf = 1'b0;
  logic [7:0]  req_b = 8'h00;
  logic        done;
  logic        taken;
  logic [23:0] next_pc;
  logic [7:0]  b_out;

  always #2.5 clk = ~clk;

  relbranch_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_disp(req_disp), .req_pc(req_pc),
    .req_zf(req_zf), .req_b(req_b), .done(done), .taken(taken),
    .next_pc(next_pc), .b_out(b_out)
  );

  typedef struct {
    int          due;
    logic        tk;
    logic [23:0] pc;
    logic [7:0]  b;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [7:0] d,
                       input logic [23:0] pc, input logic z, input logic [7:0] b);
    exp_t e;
    int n;
    while (!req_ready) @(negedge clk);
    e.b = (c == 2'b11) ? b - 8'd1 : b;
    case (c)
      2'b00: begin e.tk = 1'b1; n = 3; e.tag = "R4"; end
      2'b01: begin e.tk = ~z; n = e.tk ? 3 : 2; e.tag = "R5"; end
      2'b10: begin e.tk = z; n = e.tk ? 3 : 2; e.tag = "R5"; end
      default: begin e.tk = (e.b != 8'd0); n = e.tk ? 4 : 2; e.tag = "R6"; end
    endcase
    e.pc  = e.tk ? pc + {{16{d[7]}}, d} : pc;
    e.due = cyc + n;
    sb.push_back(e);
    req_valid = 1'b1; req_class = c; req_disp = d; req_pc = pc;
    req_zf = z; req_b = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (sb.size() > 0 && sb[0].due < cyc) begin
        chk(1'b0, "R7", "done missing at cycle", cyc, sb[0].due);
        void'(sb.pop_front());
      end
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8", "done with nothing pending", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.due, "R7", "done cycle", cyc, e.due);
          chk(taken == e.tk, e.tag, "taken", taken, e.tk);
          chk(next_pc == e.pc, e.tk ? "R2" : "R3", "next_pc", next_pc, e.pc);
          chk(b_out == e.b, (e.tag == "R6") ? "R6" : "R9", "b_out", b_out, e.b);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(taken == 1'b0, "R1", "taken", taken, 0);
    chk(next_pc == 24'h0, "R1", "next_pc", next_pc, 0);
    chk(b_out == 8'h0, "R1", "b_out", b_out, 0);

    // R4 / R2 forward, backward, wrap both ways
    issue(2'b00, 8'h05, 24'h001000, 1'b0, 8'h11);
    issue(2'b00, 8'h80, 24'h000010, 1'b1, 8'h22);
    issue(2'b00, 8'h7F, 24'hFFFFF0, 1'b0, 8'h33);
    // R5 both conditional classes, both flag values
    issue(2'b01, 8'hF0, 24'h123456, 1'b0, 8'h44);
    issue(2'b01, 8'hF0, 24'h123456, 1'b1, 8'h44);
    issue(2'b10, 8'h20, 24'h00ABCD, 1'b1, 8'h55);
    issue(2'b10, 8'h20, 24'h00ABCD, 1'b0, 8'h55);
    // R6 loop: reaches zero, continues, wraps from zero
    issue(2'b11, 8'hFE, 24'h000200, 1'b0, 8'h01);
    issue(2'b11, 8'hFE, 24'h000200, 1'b1, 8'h05);
    issue(2'b11, 8'h10, 24'h000300, 1'b0, 8'h00);
    issue(2'b11, 8'h81, 24'h000040, 1'b0, 8'h02);

    // R8 requests while busy are ignored
    issue(2'b11, 8'h04, 24'h004000, 1'b0, 8'h09);
    chk(req_ready == 1'b0, "R8", "req_ready while busy", req_ready, 0);
    req_valid = 1'b1; req_class = 2'b00; req_disp = 8'h60;
    req_pc = 24'hABCDEF; req_b = 8'h77;
    @(negedge clk);
    chk(req_ready == 1'b0, "R8", "req_ready while busy", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;

    // mixed stream
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r;
      r = $urandom;
      issue(r[1:0], r[9:2], {r[31:10], r[1:0]}, r[10], r[17:10]);
    end

    while (sb.size() > 0) @(negedge clk);
    repeat (6) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule